// File: doc/BRIEF.md
# Windowed Key-Serviced Watchdog Timer

This block is a watchdog timer that software programs through a small word-addressed register port. Software first loads a 12-bit preload. The down-counter does not start until one specific 32-bit enable key is written to the control register. Once enabled, the watchdog stays enabled until reset. Each time the counter reloads, it takes the preload scaled up by a fixed left shift, so a small field covers a long period.

Software keeps the watchdog alive by writing two key words to the key register, in order. The reload is granted only while the counter sits inside an open window at the tail of the countdown. The window size is a fraction of the reloaded value, chosen by a code register. A second key word that arrives before the window opens counts as a violation. A counter that reaches zero also counts as a violation.

Either violation sets a sticky status flag. While the flag is set, one of two reaction outputs stays high: a non-maskable interrupt request or a reset request, chosen by a reaction code.

Top module: `keyed_window_wdt`

## Requirements
- R1: After reset the watchdog is disabled and the counter reads 0. The status flag is clear and both reaction outputs are low. The window code reads 0x50, the reaction code reads 0, and the key register reads 0.
- R2: The watchdog becomes enabled only on a write of 0xA98559DA to the control register at byte offset 0x00, which then reads 1 in bit 0. A write of any other value leaves it disabled. No write disables it once it is enabled.
- R3: When the watchdog is enabled, and on each accepted service, the counter loads preload << SCALE_SHIFT. After that it falls by one per clock and holds at 0.
- R4: The preload at offset 0x04 (bits 11:0) takes writes only while the watchdog is disabled. Writes made after enabling are ignored.
- R5: A service is a write of 0xE51A to the key register at offset 0x0C, followed by a write of 0xA35C. After the first word, the key register reads 1 in bit 0. An accepted service reloads the counter.
- R6: Some writes to the key register return the sequence to its idle state, after which bit 0 reads 0. These are any value other than 0xE51A, and 0xA35C when no 0xE51A came before it. Neither case reloads the counter.
- R7: The window is open while the counter is below reload >> k. The window code at offset 0x18 (bits 7:0) selects k: 0x50 gives 1 (50%), 0x05 gives 2, 0x06 gives 3, 0x07 gives 4, and any other code gives 5. The threshold is taken from the code in force when the counter loads.
- R8: A completed key sequence while the enabled watchdog's window is closed is a violation. It sets the status flag and leaves the counter running without a reload.
- R9: An enabled counter at 0 sets the status flag on every clock.
- R10: The status flag is bit 1 at offset 0x08. Writing 1 to that bit clears the flag, unless a violation occurs in the same cycle, in which case the flag stays set.
- R11: The reaction code is at offset 0x14 (bits 3:0). With code 0xA, the interrupt output follows the flag. With any other code, the reset-request output follows the flag. The two outputs are never high together.
- R12: The live counter value reads at offset 0x10. Unused offsets and misaligned addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| nmi_o | output | 1 | Interrupt request while the flag is set and the reaction code is 0xA |
| rst_req_o | output | 1 | Reset request while the flag is set and the reaction code is not 0xA |

## Verification
The bench builds the block with PRELOAD_W at its default of 12 and SCALE_SHIFT lowered to 4. With a preload of 5, the period is therefore 80 clocks. This puts expiry, several windowed services and the recovery from a zero count inside a few hundred cycles. The shorter period also makes it practical to exercise the window codes down to the 1/16 fraction, where the open window is five counts. The full shift of 13 would need tens of thousands of clocks for each period.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

   localparam logic [31:0] KEY_ENABLE = 32'hA985_59DA;
   localparam logic [31:0] KEY_STEP1  = 32'h0000_E51A;
   localparam logic [31:0] KEY_STEP2  = 32'h0000_A35C;
   localparam logic [3:0]  REACT_IRQ  = 4'hA;
   localparam logic [7:0]  WIN_RESET  = 8'h50;

   localparam int IDX_W = 3;
   localparam logic [IDX_W-1:0] IDX_CTRL    = 3'd0;
   localparam logic [IDX_W-1:0] IDX_PRELOAD = 3'd1;
   localparam logic [IDX_W-1:0] IDX_STATUS  = 3'd2;
   localparam logic [IDX_W-1:0] IDX_KEY     = 3'd3;
   localparam logic [IDX_W-1:0] IDX_COUNT   = 3'd4;
   localparam logic [IDX_W-1:0] IDX_REACT   = 3'd5;
   localparam logic [IDX_W-1:0] IDX_WIN     = 3'd6;

   typedef enum logic {
      KS_IDLE    = 1'b0,
      KS_SERVICE = 1'b1
   } keyst_t;

   typedef struct packed {
      logic ctrl;
      logic preload;
      logic status;
      logic key;
      logic react;
      logic win;
   } wr_sel_t;

   function automatic logic [2:0] win_shift(input logic [7:0] code);
      case (code)
         8'h50:   return 3'd1;
         8'h05:   return 3'd2;
         8'h06:   return 3'd3;
         8'h07:   return 3'd4;
         default: return 3'd5;
      endcase
   endfunction

endpackage

// File: rtl/kwd_keyseq.sv
module kwd_keyseq
   import kwd_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_key,
   input  logic [31:0] wdata,
   output logic        svc_req,
   output logic        in_service
);

   keyst_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (wr_key) begin
         if (wdata == KEY_STEP1) state_d = KS_SERVICE;
         else                    state_d = KS_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= KS_IDLE;
      else        state_q <= state_d;
   end

   assign svc_req    = wr_key && (wdata == KEY_STEP2) && (state_q == KS_SERVICE);
   assign in_service = (state_q == KS_SERVICE);

   // R6
   idle_after_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      svc_req |=> !in_service);

endmodule

// File: rtl/kwd_countdown.sv
module kwd_countdown
   import kwd_pkg::*;
#(
   parameter int PRELOAD_W   = 12,
   parameter int SCALE_SHIFT = 13,
   localparam int CNT_W      = PRELOAD_W + SCALE_SHIFT
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 enabled,
   input  logic                 enable_pulse,
   input  logic                 svc_req,
   input  logic [PRELOAD_W-1:0] preload,
   input  logic [7:0]           win_code,
   output logic [CNT_W-1:0]     count,
   output logic                 expired,
   output logic                 early_viol
);

   logic [CNT_W-1:0] count_q, thresh_q, reload;
   logic             win_open, load;

   assign reload     = CNT_W'(preload) << SCALE_SHIFT;
   assign win_open   = count_q < thresh_q;
   assign load       = enable_pulse || (svc_req && enabled && win_open);
   assign early_viol = svc_req && enabled && !win_open;
   assign expired    = enabled && (count_q == '0);
   assign count      = count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q  <= '0;
         thresh_q <= '0;
      end else if (load) begin
         count_q  <= reload;
         thresh_q <= reload >> win_shift(win_code);
      end else if (enabled && (count_q != '0)) begin
         count_q  <= count_q - 1'b1;
      end
   end

   // R3
   step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enabled && !load && count_q != '0) |=> (count_q == $past(count_q) - 1'b1));

   // R5
   reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (count_q == $past(reload)));

   // R9
   hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enabled && !load && count_q == '0) |=> (count_q == '0));

endmodule

// File: rtl/kwd_regfile.sv
module kwd_regfile
   import kwd_pkg::*;
#(
   parameter int PRELOAD_W = 12
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  wr_sel_t              wsel,
   input  logic [31:0]          wdata,
   input  logic                 expired,
   input  logic                 early_viol,
   output logic                 enabled,
   output logic                 enable_pulse,
   output logic [PRELOAD_W-1:0] preload,
   output logic                 flag,
   output logic [3:0]           react,
   output logic [7:0]           win_code
);

   logic                 en_q, flag_q;
   logic [PRELOAD_W-1:0] pre_q;
   logic [3:0]           react_q;
   logic [7:0]           win_q;
   logic                 viol;

   assign enable_pulse = wsel.ctrl && (wdata == KEY_ENABLE) && !en_q;
   assign viol         = expired || early_viol;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         pre_q   <= '0;
         flag_q  <= 1'b0;
         react_q <= '0;
         win_q   <= WIN_RESET;
      end else begin
         if (enable_pulse)             en_q    <= 1'b1;
         if (wsel.preload && !en_q)    pre_q   <= wdata[PRELOAD_W-1:0];
         if (wsel.react)               react_q <= wdata[3:0];
         if (wsel.win)                 win_q   <= wdata[7:0];
         if (viol)                     flag_q  <= 1'b1;
         else if (wsel.status && wdata[1]) flag_q <= 1'b0;
      end
   end

   assign enabled  = en_q;
   assign preload  = pre_q;
   assign flag     = flag_q;
   assign react    = react_q;
   assign win_code = win_q;

   // R2
   stays_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> en_q);

   // R4
   preload_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> $stable(pre_q));

   // R8
   early_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      early_viol |=> flag_q);

   // R9
   expiry_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expired |=> flag_q);

endmodule

// File: rtl/keyed_window_wdt.sv
module keyed_window_wdt
   import kwd_pkg::*;
#(
   parameter int PRELOAD_W   = 12,
   parameter int SCALE_SHIFT = 13,
   parameter int ADDR_W      = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              nmi_o,
   output logic              rst_req_o
);

   localparam int CNT_W = PRELOAD_W + SCALE_SHIFT;

   if (PRELOAD_W < 1 || PRELOAD_W > 16) begin : g_bad_preload
      $error("PRELOAD_W must lie in 1..16");
   end
   if (SCALE_SHIFT < 0 || CNT_W > 32) begin : g_bad_shift
      $error("PRELOAD_W + SCALE_SHIFT must not exceed 32");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must be at least 5");
   end

   logic             upper_zero, addr_ok;
   logic [IDX_W-1:0] widx;
   wr_sel_t          wsel;

   if (ADDR_W > 5) begin : g_upper
      assign upper_zero = (bus_addr[ADDR_W-1:5] == '0);
   end else begin : g_noupper
      assign upper_zero = 1'b1;
   end

   assign widx    = bus_addr[4:2];
   assign addr_ok = upper_zero && (bus_addr[1:0] == 2'b00);

   always_comb begin
      wsel         = '0;
      wsel.ctrl    = bus_we && addr_ok && (widx == IDX_CTRL);
      wsel.preload = bus_we && addr_ok && (widx == IDX_PRELOAD);
      wsel.status  = bus_we && addr_ok && (widx == IDX_STATUS);
      wsel.key     = bus_we && addr_ok && (widx == IDX_KEY);
      wsel.react   = bus_we && addr_ok && (widx == IDX_REACT);
      wsel.win     = bus_we && addr_ok && (widx == IDX_WIN);
   end

   logic                 enabled, enable_pulse, flag, expired, early_viol;
   logic                 svc_req, in_service;
   logic [PRELOAD_W-1:0] preload;
   logic [3:0]           react;
   logic [7:0]           win_code;
   logic [CNT_W-1:0]     count;
   logic [31:0]          count_ext;

   kwd_regfile #(.PRELOAD_W(PRELOAD_W)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wsel         (wsel),
      .wdata        (bus_wdata),
      .expired      (expired),
      .early_viol   (early_viol),
      .enabled      (enabled),
      .enable_pulse (enable_pulse),
      .preload      (preload),
      .flag         (flag),
      .react        (react),
      .win_code     (win_code)
   );

   kwd_keyseq u_keys (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_key     (wsel.key),
      .wdata      (bus_wdata),
      .svc_req    (svc_req),
      .in_service (in_service)
   );

   kwd_countdown #(.PRELOAD_W(PRELOAD_W), .SCALE_SHIFT(SCALE_SHIFT)) u_cnt (
      .clk          (clk),
      .rst_n        (rst_n),
      .enabled      (enabled),
      .enable_pulse (enable_pulse),
      .svc_req      (svc_req),
      .preload      (preload),
      .win_code     (win_code),
      .count        (count),
      .expired      (expired),
      .early_viol   (early_viol)
   );

   if (CNT_W < 32) begin : g_cnt_pad
      assign count_ext = {{(32-CNT_W){1'b0}}, count};
   end else begin : g_cnt_full
      assign count_ext = count;
   end

   always_comb begin
      bus_rdata = '0;
      if (addr_ok) begin
         case (widx)
            IDX_CTRL:    bus_rdata[0]           = enabled;
            IDX_PRELOAD: bus_rdata[PRELOAD_W-1:0] = preload;
            IDX_STATUS:  bus_rdata[1]           = flag;
            IDX_KEY:     bus_rdata[0]           = in_service;
            IDX_COUNT:   bus_rdata              = count_ext;
            IDX_REACT:   bus_rdata[3:0]         = react;
            IDX_WIN:     bus_rdata[7:0]         = win_code;
            default:     bus_rdata              = '0;
         endcase
      end
   end

   assign nmi_o     = flag && (react == REACT_IRQ);
   assign rst_req_o = flag && (react != REACT_IRQ);

   // R11
   one_reaction_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(nmi_o && rst_req_o));

   // R11
   reaction_on_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (early_viol || expired) |=> (nmi_o || rst_req_o));

endmodule

// File: tb/sim_keyed_window_wdt.sv
module sim_keyed_window_wdt;

   localparam int PW = 12;
   localparam int SH = 4;
   localparam logic [2:0] I_CTRL = 3'd0, I_PRE = 3'd1, I_STAT = 3'd2, I_KEY = 3'd3,
                          I_CNT = 3'd4, I_REACT = 3'd5, I_WIN = 3'd6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic [7:0]  addr = 8'h10;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        nmi, rstq;

   int total = 0;
   int bad = 0;

   keyed_window_wdt #(.PRELOAD_W(PW), .SCALE_SHIFT(SH), .ADDR_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
      .bus_rdata(rdata), .nmi_o(nmi), .rst_req_o(rstq)
   );

   always #5 clk = ~clk;

   // behavioural reference state
   int m_en, m_pre, m_flag, m_react, m_win, m_cnt, m_thr, m_arm;

   function automatic int kfor(input int code);
      if (code == 'h50) return 1;
      if (code == 'h05) return 2;
      if (code == 'h06) return 3;
      if (code == 'h07) return 4;
      return 5;
   endfunction

   function automatic logic [31:0] mrd(input logic [7:0] a);
      if (a[1:0] != 2'b00 || a[7:5] != 3'b000) return 32'h0;
      case (a[4:2])
         I_CTRL:  return 32'(m_en);
         I_PRE:   return 32'(m_pre);
         I_STAT:  return 32'(m_flag * 2);
         I_KEY:   return 32'(m_arm);
         I_CNT:   return 32'(m_cnt);
         I_REACT: return 32'(m_react);
         I_WIN:   return 32'(m_win);
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_pre = 0; m_flag = 0; m_react = 0; m_win = 'h50;
         m_cnt = 0; m_thr = 0; m_arm = 0;
      end else begin
         automatic bit hit = (addr[1:0] == 2'b00) && (addr[7:5] == 3'b000);
         automatic int idx = int'(addr[4:2]);
         automatic bit enp = we && hit && idx == 0 && wdata == 32'hA98559DA && m_en == 0;
         automatic bit svc = we && hit && idx == 3 && wdata == 32'h0000A35C && m_arm == 1;
         automatic bit ld = enp || (svc && m_en == 1 && m_cnt < m_thr);
         automatic bit early = svc && m_en == 1 && !(m_cnt < m_thr);
         automatic bit expd = (m_en == 1) && (m_cnt == 0);
         automatic int reload = m_pre << SH;
         if (ld) begin
            m_thr = reload >> kfor(m_win);
            m_cnt = reload;
         end else if (m_en == 1 && m_cnt > 0) m_cnt = m_cnt - 1;
         if (early || expd) m_flag = 1;
         else if (we && hit && idx == 2 && wdata[1]) m_flag = 0;
         if (we && hit && idx == 1 && m_en == 0) m_pre = int'(wdata[11:0]);
         if (we && hit && idx == 5) m_react = int'(wdata[3:0]);
         if (we && hit && idx == 6) m_win = int'(wdata[7:0]);
         if (we && hit && idx == 3) m_arm = (wdata == 32'h0000E51A) ? 1 : 0;
         if (enp) m_en = 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      #2;
      if (rst_n) begin
         if (!we) chk("R12 readback vs model", rdata, mrd(addr));
         chk("R11 nmi vs model", 32'(nmi), 32'((m_flag == 1) && (m_react == 'hA)));
         chk("R11 reset request vs model", 32'(rstq), 32'((m_flag == 1) && (m_react != 'hA)));
      end
   end

   task automatic wr(input logic [2:0] i, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = {3'b000, i, 2'b00}; wdata = d;
      @(negedge clk);
      we = 1'b0; addr = {3'b000, I_CNT, 2'b00}; wdata = '0;
   endtask

   task automatic rd(input logic [2:0] i, input logic [31:0] exp, input string tag);
      addr = {3'b000, i, 2'b00};
      #1;
      chk(tag, rdata, exp);
   endtask

   task automatic wait_below(input int n);
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         addr = {3'b000, I_CNT, 2'b00};
         #1;
         if (rdata < 32'(n)) break;
      end
   endtask

   task automatic service();
      wr(I_KEY, 32'h0000E51A);
      wr(I_KEY, 32'h0000A35C);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired before the run ended");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(I_CTRL, 0, "R1 control after reset");
      rd(I_CNT, 0, "R1 counter after reset");
      rd(I_STAT, 0, "R1 status after reset");
      rd(I_WIN, 32'h50, "R1 window code after reset");
      rd(I_REACT, 0, "R1 reaction code after reset");
      rd(I_KEY, 0, "R1 key state after reset");
      chk("R1 outputs low after reset", {30'b0, nmi, rstq}, 0);

      // R12 misaligned read gives zero
      addr = 8'h11; #1; chk("R12 misaligned read", rdata, 0);

      wr(I_PRE, 32'hFFFF_F005);
      rd(I_PRE, 32'h005, "R4 preload writable while disabled");
      wr(I_CTRL, 32'h1234_5678);
      rd(I_CTRL, 0, "R2 wrong enable key ignored");
      rd(I_CNT, 0, "R2 counter idle while disabled");
      wr(I_CTRL, 32'hA985_59DA);
      rd(I_CNT, 80, "R3 counter loads preload<<shift on enable");
      rd(I_CTRL, 1, "R2 enabled after key");
      @(negedge clk);
      rd(I_CNT, 79, "R3 counter steps down by one");
      wr(I_PRE, 32'h9);
      rd(I_PRE, 32'h5, "R4 preload locked when enabled");
      wr(I_CTRL, 32'h0);
      rd(I_CTRL, 1, "R2 cannot be disabled");

      // R8 early service
      wr(I_KEY, 32'h0000E51A);
      rd(I_KEY, 1, "R5 service state after first key");
      wr(I_KEY, 32'h0000A35C);
      rd(I_STAT, 2, "R8 early service flags violation");
      chk("R11 default reaction is reset request", {30'b0, nmi, rstq}, 32'b01);
      addr = {3'b000, I_CNT, 2'b00}; #1;
      chk("R8 no reload on early service", 32'(rdata < 80), 1);
      wr(I_STAT, 32'h2);
      rd(I_STAT, 0, "R10 write-one clears flag");

      // R7 window at 50 percent: threshold 40
      wait_below(40);
      service();
      rd(I_CNT, 80, "R5 service in window reloads");
      rd(I_STAT, 0, "R7 in-window service is no violation");

      // R6 bad sequences
      wait_below(40);
      wr(I_KEY, 32'h0000A35C);
      rd(I_KEY, 0, "R6 lone second key stays idle");
      addr = {3'b000, I_CNT, 2'b00}; #1;
      chk("R6 lone second key does not reload", 32'(rdata < 40), 1);
      wr(I_KEY, 32'h0000E51A);
      wr(I_KEY, 32'h0000BEEF);
      rd(I_KEY, 0, "R6 wrong key resets sequence");
      wr(I_KEY, 32'h0000A35C);
      addr = {3'b000, I_CNT, 2'b00}; #1;
      chk("R6 broken sequence does not reload", 32'(rdata < 40), 1);
      rd(I_STAT, 0, "R6 broken sequence raises no flag");

      // R9 expiry with interrupt reaction
      wr(I_REACT, 32'hA);
      rd(I_REACT, 32'hA, "R11 reaction code readback");
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         if (nmi) break;
      end
      #1;
      chk("R9 expiry raises interrupt", {30'b0, nmi, rstq}, 32'b10);
      rd(I_CNT, 0, "R9 counter holds at zero");
      rd(I_STAT, 2, "R9 expiry sets flag");
      wr(I_STAT, 32'h2);
      rd(I_STAT, 2, "R10 violation wins over clear");
      service();
      rd(I_CNT, 80, "R3 service from zero reloads");
      wr(I_STAT, 32'h2);
      rd(I_STAT, 0, "R10 clear after recovery");
      chk("R11 outputs low once cleared", {30'b0, nmi, rstq}, 0);

      // R7 window code 0x07 gives 1/16: threshold 5 from next load
      wr(I_WIN, 32'h07);
      wait_below(40);
      service();
      rd(I_CNT, 80, "R7 reload under old threshold");
      wait_below(21);
      service();
      rd(I_STAT, 2, "R7 narrow window rejects count near 20");
      wr(I_STAT, 32'h2);
      wait_below(5);
      service();
      rd(I_CNT, 80, "R7 narrow window accepts low count");
      rd(I_STAT, 0, "R7 no violation inside narrow window");

      // R1 second reset
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd(I_CTRL, 0, "R1 disabled after second reset");
      rd(I_CNT, 0, "R1 counter cleared after second reset");

      repeat (3) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule